// File: doc/BRIEF.md
# Watermark-Driven Page Frame Evictor

The block tracks recent use for a fixed set of resident page frames and chooses which ones to give up when free memory runs short. Each frame has a one-bit staleness flag and a saturating age counter. A use of a frame makes it young: the flag and the age both return to zero. A periodic aging pulse sets the flag of every young frame. For frames whose flag is already set, the pulse increments the age instead. Frames with the flag set are the candidates for eviction.

The surrounding memory manager reports the free-frame count on every cycle and programs a low and a high watermark. When the count drops to the low mark and the high mark lies above the count, the block takes the shortfall to the high mark and emits that many victim indices. It issues one victim per cycle, each with a single-cycle strobe. Victims are chosen in one of two ways. Aging selection takes the stalest, oldest frame. Not-recently-used selection makes a pseudo-random pick among the stale frames. A reported frame's history is cleared, because its slot is about to be refilled.

Top module: `page_evictor`

## Requirements
- R1: When no burst is in progress and, at a rising edge, `free_count <= low_mark` and `high_mark > free_count`, the block latches a demand of `high_mark - free_count`. Starting at the next rising edge, it raises `evict_valid` for exactly that many consecutive cycles. The free count is then sampled again at the edge after the last strobe is registered.
- R2: A `touch_valid` pulse with index `touch_idx` clears that frame's flag and its age to 0.
- R3: On an `age_tick` edge, a frame with flag 0 gets flag 1 and keeps its age. A frame with flag 1 has its 4-bit age incremented, saturating at 15.
- R4: When a touch and a tick reach the same frame in the same cycle, the touch wins and the frame ends with flag 0 and age 0.
- R5: With `nru_mode = 0`, the victim is the frame with flag 1 and the largest age. Ties go to the lowest index.
- R6: With `nru_mode = 1`, the victim is the first frame with flag 1, scanning upward with wrap-around from the start index. The start index is the low 4 bits of a 16-bit shift register. The register resets to 0xACE1 and shifts left on every cycle out of reset, with new bit 0 = b15 ^ b13 ^ b12 ^ b10. The value used is the one held just before the edge that registers the victim.
- R7: If no frame has flag 1, the victim is the frame with the largest age overall, lowest index on ties, in either mode.
- R8: A frame reported as a victim has its flag and age cleared at the same edge that registers `evict_valid`.
- R9: After reset, `evict_valid` is 0, every flag and age is 0, and no burst is pending.
- R10: The selection mode is sampled separately for each victim, so `nru_mode` may change in the middle of a burst.
- R11: If `high_mark <= free_count` when the low mark is reached, no victim is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nru_mode | input | 1 | 0 selects aging choice, 1 selects random not-recently-used choice |
| low_mark | input | 8 | Free count at or below which a burst starts |
| high_mark | input | 8 | Free count a burst restores |
| free_count | input | 8 | Current number of free frames |
| age_tick | input | 1 | Periodic aging pulse |
| touch_valid | input | 1 | A frame was used this cycle |
| touch_idx | input | 4 | Index of the used frame |
| evict_valid | output | 1 | One-cycle strobe per reported victim |
| evict_idx | output | 4 | Index of the reported victim |

## Verification
Saturated age counters are the hardest state to reach from the ports, because ages are only seen through which frame wins an eviction. The stimulus applies more than fifteen aging pulses, then touches one frame so that it alone falls back. A wrapping counter would then change the winners, while saturated ties resolve to the lowest index. A second hard case is a burst during which the selection mode changes on every cycle and a later burst starts while the shift register is at some arbitrary phase. A behavioural model of the register and the scan predicts each victim in these cases.

// File: rtl/page_evict_pkg.sv
package page_evict_pkg;
  localparam int RAND_W = 16;
  localparam logic [RAND_W-1:0] RAND_SEED = 16'hACE1;

  function automatic logic [RAND_W-1:0] rand_step(input logic [RAND_W-1:0] s);
    return {s[RAND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/pe_rand_gen.sv
module pe_rand_gen
  import page_evict_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [RAND_W-1:0] state_q
);
  always_ff @(posedge clk) begin
    if (rst) state_q <= RAND_SEED;
    else     state_q <= rand_step(state_q);
  end
endmodule

// File: rtl/pe_frame_table.sv
module pe_frame_table #(
  parameter int N_FRAMES = 16,
  parameter int AGE_W    = 4,
  localparam int IDX_W   = $clog2(N_FRAMES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      age_tick,
  input  logic                      touch_valid,
  input  logic [IDX_W-1:0]          touch_idx,
  input  logic                      clr_valid,
  input  logic [IDX_W-1:0]          clr_idx,
  output logic [N_FRAMES-1:0]       flag_vec,
  output logic [N_FRAMES*AGE_W-1:0] age_flat
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
    logic             stale_q;
    logic [AGE_W-1:0] age_q;
    logic             wipe;

    assign wipe = (touch_valid && touch_idx == IDX_W'(g)) ||
                  (clr_valid && clr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        stale_q <= 1'b0;
        age_q   <= '0;
      end else if (wipe) begin
        stale_q <= 1'b0;
        age_q   <= '0;
      end else if (age_tick) begin
        if (!stale_q)              stale_q <= 1'b1;
        else if (age_q != AGE_MAX) age_q   <= age_q + 1'b1;
      end
    end

    assign flag_vec[g] = stale_q;
    assign age_flat[g*AGE_W +: AGE_W] = age_q;
  end
endmodule

// File: rtl/pe_victim_pick.sv
module pe_victim_pick #(
  parameter int N_FRAMES = 16,
  parameter int AGE_W    = 4,
  localparam int IDX_W   = $clog2(N_FRAMES)
) (
  input  logic [N_FRAMES-1:0]       flag_vec,
  input  logic [N_FRAMES*AGE_W-1:0] age_flat,
  input  logic                      use_nru,
  input  logic [IDX_W-1:0]          start_idx,
  output logic [IDX_W-1:0]          victim_idx
);
  logic [AGE_W-1:0] age_arr [N_FRAMES];
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_unpack
    assign age_arr[g] = age_flat[g*AGE_W +: AGE_W];
  end

  logic [IDX_W-1:0] stale_idx, any_idx, scan_idx;
  logic [AGE_W-1:0] stale_age, any_age;
  logic             stale_hit, scan_hit;

  // Oldest stale frame and oldest frame overall; strict compare keeps lowest index on ties
  always_comb begin
    stale_hit = 1'b0;
    stale_idx = '0;
    stale_age = '0;
    any_idx   = '0;
    any_age   = '0;
    for (int i = 0; i < N_FRAMES; i++) begin
      if (flag_vec[i] && (!stale_hit || age_arr[i] > stale_age)) begin
        stale_hit = 1'b1;
        stale_idx = IDX_W'(i);
        stale_age = age_arr[i];
      end
      if (age_arr[i] > any_age) begin
        any_idx = IDX_W'(i);
        any_age = age_arr[i];
      end
    end
  end

  // Forward circular scan from the random start
  always_comb begin
    logic [IDX_W-1:0] pos;
    pos      = '0;
    scan_hit = 1'b0;
    scan_idx = '0;
    for (int k = 0; k < N_FRAMES; k++) begin
      pos = start_idx + IDX_W'(k);
      if (!scan_hit && flag_vec[pos]) begin
        scan_hit = 1'b1;
        scan_idx = pos;
      end
    end
  end

  always_comb begin
    if (!(|flag_vec)) victim_idx = any_idx;
    else if (use_nru) victim_idx = scan_idx;
    else              victim_idx = stale_idx;
  end
endmodule

// File: rtl/pe_burst_ctrl.sv
module pe_burst_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] free_count,
  input  logic [CNT_W-1:0] low_mark,
  input  logic [CNT_W-1:0] high_mark,
  output logic [CNT_W-1:0] need_q,
  output logic             fire
);
  logic starve;
  assign starve = (free_count <= low_mark) && (high_mark > free_count);

  always_ff @(posedge clk) begin
    if (rst)               need_q <= '0;
    else if (need_q != '0) need_q <= need_q - 1'b1;
    else if (starve)       need_q <= high_mark - free_count;
  end

  assign fire = (need_q != '0);
endmodule

// File: rtl/page_evictor.sv
module page_evictor
  import page_evict_pkg::*;
#(
  parameter int N_FRAMES = 16,
  parameter int AGE_W    = 4,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(N_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nru_mode,
  input  logic [CNT_W-1:0] low_mark,
  input  logic [CNT_W-1:0] high_mark,
  input  logic [CNT_W-1:0] free_count,
  input  logic             age_tick,
  input  logic             touch_valid,
  input  logic [IDX_W-1:0] touch_idx,
  output logic             evict_valid,
  output logic [IDX_W-1:0] evict_idx
);
  logic [N_FRAMES-1:0]       flag_vec;
  logic [N_FRAMES*AGE_W-1:0] age_flat;
  logic [CNT_W-1:0]          need_q;
  logic                      fire;
  logic [IDX_W-1:0]          victim;
  logic [RAND_W-1:0]         rand_q;

  pe_rand_gen u_rand (
    .clk     (clk),
    .rst     (rst),
    .state_q (rand_q)
  );

  pe_burst_ctrl #(.CNT_W(CNT_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .free_count (free_count),
    .low_mark   (low_mark),
    .high_mark  (high_mark),
    .need_q     (need_q),
    .fire       (fire)
  );

  pe_frame_table #(.N_FRAMES(N_FRAMES), .AGE_W(AGE_W)) u_table (
    .clk         (clk),
    .rst         (rst),
    .age_tick    (age_tick),
    .touch_valid (touch_valid),
    .touch_idx   (touch_idx),
    .clr_valid   (fire),
    .clr_idx     (victim),
    .flag_vec    (flag_vec),
    .age_flat    (age_flat)
  );

  pe_victim_pick #(.N_FRAMES(N_FRAMES), .AGE_W(AGE_W)) u_pick (
    .flag_vec   (flag_vec),
    .age_flat   (age_flat),
    .use_nru    (nru_mode),
    .start_idx  (rand_q[IDX_W-1:0]),
    .victim_idx (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      evict_valid <= 1'b0;
      evict_idx   <= '0;
    end else begin
      evict_valid <= fire;
      if (fire) evict_idx <= victim;
    end
  end
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
  parameter int N_FRAMES = 16,
  parameter int AGE_W    = 4,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(N_FRAMES)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      touch_valid,
  input logic [IDX_W-1:0]          touch_idx,
  input logic                      evict_valid,
  input logic [IDX_W-1:0]          evict_idx,
  input logic [N_FRAMES-1:0]       flag_vec,
  input logic [N_FRAMES*AGE_W-1:0] age_flat,
  input logic [CNT_W-1:0]          need_q
);
  a_r1_need_countdown: assert property (@(posedge clk) disable iff (rst)
    (need_q != '0) |=> (need_q == $past(need_q) - 1'b1));

  a_r1_strobe_needs_demand: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> ($past(need_q) != '0));

  for (genvar g = 0; g < N_FRAMES; g++) begin : g_chk
    a_r2_touch_clears: assert property (@(posedge clk) disable iff (rst)
      (touch_valid && touch_idx == IDX_W'(g)) |=>
        (!flag_vec[g] && age_flat[g*AGE_W +: AGE_W] == '0));

    a_r3_age_step: assert property (@(posedge clk) disable iff (rst)
      (age_flat[g*AGE_W +: AGE_W] == $past(age_flat[g*AGE_W +: AGE_W])) ||
      (age_flat[g*AGE_W +: AGE_W] == $past(age_flat[g*AGE_W +: AGE_W]) + 1'b1) ||
      (age_flat[g*AGE_W +: AGE_W] == '0));

    a_r8_victim_cleared: assert property (@(posedge clk) disable iff (rst)
      (evict_valid && evict_idx == IDX_W'(g)) |->
        (!flag_vec[g] && age_flat[g*AGE_W +: AGE_W] == '0));

    a_r5_victim_was_stale: assert property (@(posedge clk) disable iff (rst)
      (evict_valid && evict_idx == IDX_W'(g) && $past(|flag_vec)) |->
        $past(flag_vec[g]));
  end
endmodule

bind page_evictor pe_checker #(
  .N_FRAMES(N_FRAMES), .AGE_W(AGE_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .touch_valid (touch_valid),
  .touch_idx   (touch_idx),
  .evict_valid (evict_valid),
  .evict_idx   (evict_idx),
  .flag_vec    (flag_vec),
  .age_flat    (age_flat),
  .need_q      (need_q)
);

// File: tb/page_evictor_tb.sv
`timescale 1ns/1ps
module page_evictor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nru_mode = 1'b0;
  logic [7:0] low_mark = 8'd2;
  logic [7:0] high_mark = 8'd6;
  logic [7:0] free_count = 8'd100;
  logic       age_tick = 1'b0;
  logic       touch_valid = 1'b0;
  logic [3:0] touch_idx = 4'd0;
  logic       evict_valid;
  logic [3:0] evict_idx;

  always #2 clk = ~clk;

  page_evictor u_dut (
    .clk(clk), .rst(rst), .nru_mode(nru_mode), .low_mark(low_mark),
    .high_mark(high_mark), .free_count(free_count), .age_tick(age_tick),
    .touch_valid(touch_valid), .touch_idx(touch_idx),
    .evict_valid(evict_valid), .evict_idx(evict_idx)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R9";

  // Behavioural reference model
  int m_flag [16];
  int m_age [16];
  int m_need;
  logic [15:0] m_rng;
  bit exp_valid;
  int exp_idx;
  int m_v;
  bit m_ev;

  function automatic int pick(bit nru);
    int best, oldest, start, j;
    bit any;
    best = -1; oldest = 0; any = 0;
    for (int i = 0; i < 16; i++) if (m_flag[i] != 0) any = 1;
    if (!any) begin
      for (int i = 0; i < 16; i++) if (m_age[i] > m_age[oldest]) oldest = i;
      return oldest;
    end
    if (nru) begin
      start = int'(m_rng[3:0]);
      for (int k = 0; k < 16; k++) begin
        j = (start + k) % 16;
        if (m_flag[j] != 0) return j;
      end
    end
    for (int i = 0; i < 16; i++)
      if (m_flag[i] != 0 && (best < 0 || m_age[i] > m_age[best])) best = i;
    return best;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin m_flag[i] = 0; m_age[i] = 0; end
      m_need = 0; m_rng = 16'hACE1; exp_valid = 0; exp_idx = 0;
    end else begin
      m_ev = (m_need > 0);
      m_v = m_ev ? pick(nru_mode) : -1;
      exp_valid = m_ev;
      if (m_ev) exp_idx = m_v;
      for (int i = 0; i < 16; i++) begin
        if ((touch_valid && int'(touch_idx) == i) || (m_ev && m_v == i)) begin
          m_flag[i] = 0; m_age[i] = 0;
        end else if (age_tick) begin
          if (m_flag[i] == 0) m_flag[i] = 1;
          else if (m_age[i] < 15) m_age[i] = m_age[i] + 1;
        end
      end
      if (m_need > 0) m_need = m_need - 1;
      else if (free_count <= low_mark && high_mark > free_count)
        m_need = int'(high_mark) - int'(free_count);
      m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (evict_valid !== exp_valid) begin
        fails++;
        $display("FAIL %s evict_valid actual %0b expected %0b", cur_req, evict_valid, exp_valid);
      end else if (exp_valid && int'(evict_idx) != exp_idx) begin
        fails++;
        $display("FAIL %s evict_idx actual %0d expected %0d", cur_req, evict_idx, exp_idx);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
      summary();
      $finish;
    end
  end

  task automatic tick_n(int n);
    repeat (n) begin age_tick = 1'b1; @(negedge clk); end
    age_tick = 1'b0;
  endtask

  task automatic touch(int idx);
    touch_valid = 1'b1; touch_idx = 4'(idx); @(negedge clk);
    touch_valid = 1'b0;
  endtask

  task automatic burst(int f);
    free_count = 8'(f); @(negedge clk);
    free_count = 8'd100;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    cur_req = "R9";
    checks++;
    if (evict_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 evict_valid after reset actual %0b expected 0", evict_valid);
    end
    repeat (4) @(negedge clk);

    // R7: no stale frame, oldest overall wins
    cur_req = "R7";
    burst(2);

    // R2 and R5: touched frames fall back, oldest stale lowest index
    cur_req = "R5";
    tick_n(1); touch(3); touch(7); tick_n(3); touch(5);
    cur_req = "R2";
    burst(3);

    // R4: touch and tick on the same cycle
    cur_req = "R4";
    touch_valid = 1'b1; touch_idx = 4'd12; age_tick = 1'b1; @(negedge clk);
    touch_valid = 1'b0; age_tick = 1'b0;
    tick_n(2);
    burst(4);

    // R3: saturation at 15
    cur_req = "R3";
    tick_n(20); touch(9); tick_n(2);
    burst(2);

    // R8: victims become young, next burst picks others
    cur_req = "R8";
    tick_n(3); burst(4); tick_n(1); burst(4);

    // R6: random not-recently-used choice
    cur_req = "R6";
    nru_mode = 1'b1;
    tick_n(2); touch(1); touch(14); tick_n(1);
    burst(0);
    tick_n(3); burst(3);

    // R10: mode changes mid-burst
    cur_req = "R10";
    tick_n(4);
    low_mark = 8'd8; high_mark = 8'd16;
    free_count = 8'd4; @(negedge clk);
    free_count = 8'd100;
    for (int c = 0; c < 14; c++) begin nru_mode = ~nru_mode; @(negedge clk); end
    repeat (4) @(negedge clk);

    // R11: high mark not above free count
    cur_req = "R11";
    nru_mode = 1'b0;
    low_mark = 8'd5; high_mark = 8'd3; free_count = 8'd4;
    repeat (10) @(negedge clk);
    high_mark = 8'd4;
    repeat (10) @(negedge clk);

    // R1: long burst, then repeated bursts while count stays low
    cur_req = "R1";
    free_count = 8'd100; low_mark = 8'd10; high_mark = 8'd16;
    tick_n(5);
    burst(3);
    low_mark = 8'd2; high_mark = 8'd6;
    tick_n(2);
    free_count = 8'd1;
    repeat (30) @(negedge clk);
    free_count = 8'd100;
    repeat (10) @(negedge clk);

    summary();
    $finish;
  end
endmodule